// File: doc/BRIEF.md
# Shared-Adder Accumulator ALU

This block is the arithmetic core of a small 8-bit accumulator processor. A single binary adder handles add-with-carry, subtract-with-borrow and compare. For subtraction the second operand is bit-inverted before it reaches the adder. The incoming carry flag passes through untouched, so carry set means "no borrow pending". A separate shift unit handles one-bit logical shifts and rotates through carry. The unit holds no state and every output is a combinational function of the current inputs.

The surrounding datapath presents the accumulator, the second operand, the current carry and overflow flags, and a 3-bit operation code. It takes back the result, the four flags, and a write-enable that tells it whether the accumulator should load the result. Software that wants a plain add or a plain subtract must first clear or set carry, because no such operations exist here.

Top module: `cs_alu`

## Requirements
- R1: With op_i = 0 (add), {carry_o, result_o} equals acc_i + opnd_i + carry_i, and wr_en_o is 1.
- R2: With op_i = 1 (subtract), result_o equals (acc_i - opnd_i - (1 - carry_i)) mod 256. carry_o is 1 exactly when no borrow occurred (acc_i >= opnd_i + (1 - carry_i)). wr_en_o is 1.
- R3: With op_i = 2 (compare), result_o equals (acc_i - opnd_i) mod 256 whatever carry_i is. carry_o is 1 exactly when acc_i >= opnd_i, and wr_en_o is 0.
- R4: zero_o is 1 exactly when result_o is all zeros, for every op_i.
- R5: neg_o equals result_o bit 7, for every op_i.
- R6: For add and subtract, ovf_o is 1 exactly when the signed (two's complement) true result of the operation lies outside -128..127.
- R7: For op_i values 2 to 7, ovf_o equals ovf_i.
- R8: With op_i = 3 (shift left), result_o is acc_i shifted left one place with 0 entering bit 0, carry_o is acc_i bit 7, and wr_en_o is 1.
- R9: With op_i = 4 (logical shift right), result_o is acc_i shifted right one place with 0 entering bit 7, carry_o is acc_i bit 0, and wr_en_o is 1.
- R10: With op_i = 5 (rotate left), result_o is acc_i shifted left with carry_i entering bit 0, carry_o is acc_i bit 7, and wr_en_o is 1.
- R11: With op_i = 6 (rotate right), result_o is acc_i shifted right with carry_i entering bit 7, carry_o is acc_i bit 0, and wr_en_o is 1.
- R12: op_i = 7 is reserved. result_o equals acc_i, carry_o equals carry_i, and wr_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | WIDTH (8) | Accumulator operand |
| opnd_i | input | WIDTH (8) | Second operand, used by add, subtract and compare |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag, passed through where unchanged |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 shl, 4 shr, 5 rol, 6 ror, 7 reserved) |
| result_o | output | WIDTH (8) | Operation result |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result most significant bit |
| ovf_o | output | 1 | New overflow flag |
| wr_en_o | output | 1 | Result should be written to the accumulator |

## Verification
The checker assumes the inputs settle within a cycle, and it compares each output only after that. It also assumes op_i is never unknown, because every one of the eight codes is defined and the checker picks its rule from op_i. The bench changes inputs only on the falling clock edge and samples a nanosecond later. It drives only fully known values, so every input stays within those assumptions. The stimulus mixes a hand-built table of carry, borrow, sign-crossing and zero-result cases with strided sweeps of both operands under both carry values.

// File: rtl/cs_alu_pkg.sv
package cs_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMP  = 3'd2,
      OP_SHL  = 3'd3,
      OP_SHR  = 3'd4,
      OP_ROL  = 3'd5,
      OP_ROR  = 3'd6,
      OP_NONE = 3'd7
   } cs_alu_op_e;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_INFER  = 1;

endpackage

// File: rtl/cs_alu_adder.sv
module cs_alu_adder #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cs_alu_adder: WIDTH must be at least 2");
      end
      if (ADDER_STYLE == cs_alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic half;
            assign half       = a_i[i] ^ b_i[i];
            assign sum_o[i]   = half ^ chain[i];
            assign chain[i+1] = (a_i[i] & b_i[i]) | (half & chain[i]);
         end
         assign cout_o = chain[WIDTH];
         assign ovf_o  = chain[WIDTH] ^ chain[MSB];
      end else if (ADDER_STYLE == cs_alu_pkg::ADDER_INFER) begin : g_infer
         logic [WIDTH:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
         assign sum_o  = wide[MSB:0];
         assign cout_o = wide[WIDTH];
         assign ovf_o  = (a_i[MSB] == b_i[MSB]) && (wide[MSB] != a_i[MSB]);
      end else begin : g_bad_style
         $error("cs_alu_adder: unknown ADDER_STYLE");
      end
   endgenerate

endmodule

// File: rtl/cs_alu_shifter.sv
module cs_alu_shifter #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             fill_i,
   input  logic             right_i,
   output logic [WIDTH-1:0] res_o,
   output logic             out_bit_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cs_alu_shifter: WIDTH must be at least 2");
      end
   endgenerate

   always_comb begin
      if (right_i) begin
         res_o     = {fill_i, a_i[MSB:1]};
         out_bit_o = a_i[0];
      end else begin
         res_o     = {a_i[MSB-1:0], fill_i};
         out_bit_o = a_i[MSB];
      end
   end

endmodule

// File: rtl/cs_alu_flags.sv
module cs_alu_flags #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] res_i,
   output logic             zero_o,
   output logic             neg_o
);
   assign zero_o = ~|res_i;
   assign neg_o  = res_i[WIDTH-1];
endmodule

// File: rtl/cs_alu.sv
module cs_alu #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = cs_alu_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] opnd_i,
   input  logic             carry_i,
   input  logic             ovf_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             zero_o,
   output logic             neg_o,
   output logic             ovf_o,
   output logic             wr_en_o
);
   import cs_alu_pkg::*;

   cs_alu_op_e op;
   assign op = cs_alu_op_e'(op_i);

   // Operand conditioning: invert for subtract/compare, carry never inverted.
   logic             invert_b;
   logic [WIDTH-1:0] add_b;
   logic             add_cin;
   assign invert_b = (op == OP_SUB) || (op == OP_CMP);
   assign add_b    = invert_b ? ~opnd_i : opnd_i;
   assign add_cin  = (op == OP_CMP) ? 1'b1 : carry_i;

   logic [WIDTH-1:0] sum;
   logic             sum_cout;
   logic             sum_ovf;

   cs_alu_adder #(
      .WIDTH      (WIDTH),
      .ADDER_STYLE(ADDER_STYLE)
   ) u_adder (
      .a_i   (acc_i),
      .b_i   (add_b),
      .cin_i (add_cin),
      .sum_o (sum),
      .cout_o(sum_cout),
      .ovf_o (sum_ovf)
   );

   // Shift unit: rotates feed the old carry in, logical shifts feed 0.
   logic             shift_right;
   logic             shift_fill;
   logic [WIDTH-1:0] shifted;
   logic             shift_out;
   assign shift_right = (op == OP_SHR) || (op == OP_ROR);
   assign shift_fill  = ((op == OP_ROL) || (op == OP_ROR)) ? carry_i : 1'b0;

   cs_alu_shifter #(
      .WIDTH(WIDTH)
   ) u_shifter (
      .a_i      (acc_i),
      .fill_i   (shift_fill),
      .right_i  (shift_right),
      .res_o    (shifted),
      .out_bit_o(shift_out)
   );

   always_comb begin
      result_o = acc_i;
      carry_o  = carry_i;
      ovf_o    = ovf_i;
      wr_en_o  = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            result_o = sum;
            carry_o  = sum_cout;
            ovf_o    = sum_ovf;
            wr_en_o  = 1'b1;
         end
         OP_CMP: begin
            result_o = sum;
            carry_o  = sum_cout;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            result_o = shifted;
            carry_o  = shift_out;
            wr_en_o  = 1'b1;
         end
         OP_NONE: begin
            result_o = acc_i;
         end
         default: begin
            result_o = acc_i;
         end
      endcase
   end

   cs_alu_flags #(
      .WIDTH(WIDTH)
   ) u_flags (
      .res_i (result_o),
      .zero_o(zero_o),
      .neg_o (neg_o)
   );

endmodule

// File: rtl/cs_alu_chk.sv
module cs_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] acc_i,
   input logic [WIDTH-1:0] opnd_i,
   input logic             carry_i,
   input logic             ovf_i,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o,
   input logic             zero_o,
   input logic             neg_o,
   input logic             ovf_o,
   input logic             wr_en_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] add_ref;
   logic [WIDTH:0] sub_need;
   assign add_ref  = {1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, carry_i};
   assign sub_need = {1'b0, opnd_i} + {{WIDTH{1'b0}}, ~carry_i};

   always_comb begin
      if (op_i == 3'd0)
         AST_ADD_SUM: assert ({carry_o, result_o} == add_ref); // R1
      if (op_i == 3'd1)
         AST_SUB_BORROW: assert (carry_o == ({1'b0, acc_i} >= sub_need)); // R2
      if (op_i == 3'd2)
         AST_CMP_NO_WRITE: assert (!wr_en_o && (carry_o == (acc_i >= opnd_i))); // R3
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R4
      AST_NEG_FLAG: assert (neg_o == result_o[MSB]); // R5
      if (op_i >= 3'd2)
         AST_OVF_HELD: assert (ovf_o == ovf_i); // R7
      if (op_i == 3'd4)
         AST_SHR_TOP_CLEAR: assert (!result_o[MSB] && carry_o == acc_i[0]); // R9
      if (op_i == 3'd7)
         AST_NONE_IDLE: assert (!wr_en_o && result_o == acc_i && carry_o == carry_i); // R12
   end

endmodule

bind cs_alu cs_alu_chk #(
   .WIDTH(WIDTH)
) u_chk (
   .acc_i   (acc_i),
   .opnd_i  (opnd_i),
   .carry_i (carry_i),
   .ovf_i   (ovf_i),
   .op_i    (op_i),
   .result_o(result_o),
   .carry_o (carry_o),
   .zero_o  (zero_o),
   .neg_o   (neg_o),
   .ovf_o   (ovf_o),
   .wr_en_o (wr_en_o)
);

// File: tb/cs_alu_tb.sv
module cs_alu_tb;
   logic       clk = 1'b0;
   logic [7:0] acc, opnd;
   logic       cin, vin;
   logic [2:0] op;
   logic [7:0] res;
   logic       cout, zf, nf, vf, we;
   int         errors = 0;
   int         checks = 0;

   always #5 clk = ~clk;

   cs_alu u_dut (
      .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .ovf_i(vin), .op_i(op),
      .result_o(res), .carry_o(cout), .zero_o(zf), .neg_o(nf),
      .ovf_o(vf), .wr_en_o(we)
   );

   // {op, a, b, cin, vin, exp_res, exp_c, exp_v, exp_we}
   localparam int NVEC = 14;
   localparam logic [31:0] VEC [NVEC] = '{
      {3'd0, 8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 1'b0, 1'b1, 1'b1},
      {3'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1},
      {3'd0, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1},
      {3'd1, 8'h50, 8'hF0, 1'b1, 1'b1, 8'h60, 1'b0, 1'b0, 1'b1},
      {3'd1, 8'h50, 8'h30, 1'b0, 1'b0, 8'h1F, 1'b1, 1'b0, 1'b1},
      {3'd1, 8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b1},
      {3'd2, 8'h10, 8'h10, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
      {3'd2, 8'h05, 8'h06, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0},
      {3'd3, 8'h81, 8'h00, 1'b0, 1'b1, 8'h02, 1'b1, 1'b1, 1'b1},
      {3'd4, 8'h01, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
      {3'd5, 8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1},
      {3'd6, 8'h01, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1},
      {3'd6, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0, 1'b1},
      {3'd7, 8'h3C, 8'h99, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h c=%0b)",
                  tag, act, exp, op, acc, opnd, cin);
      end
   endtask

   function automatic string op_tag(input logic [2:0] o);
      case (o)
         3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
         3'd3: return "R8"; 3'd4: return "R9"; 3'd5: return "R10";
         3'd6: return "R11"; default: return "R12";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic v);
      @(negedge clk);
      op = o; acc = a; opnd = b; cin = c; vin = v;
      #1;
   endtask

   // Independent arithmetic model for add/sub/cmp sweeps.
   task automatic sweep_check(input logic [2:0] o, input logic [7:0] a,
                              input logic [7:0] b, input logic c);
      int s, ss, ec, ev;
      apply(o, a, b, c, 1'b1);
      if (o == 3'd0) begin
         s  = int'(a) + int'(b) + int'(c);
         ss = int'($signed(a)) + int'($signed(b)) + int'(c);
         ec = (s > 255) ? 1 : 0;
      end else begin
         s  = int'(a) - int'(b) - ((o == 3'd2) ? 0 : 1 - int'(c));
         ss = int'($signed(a)) - int'($signed(b)) - ((o == 3'd2) ? 0 : 1 - int'(c));
         ec = (s >= 0) ? 1 : 0;
      end
      ev = (o == 3'd2) ? 1 : ((ss > 127 || ss < -128) ? 1 : 0);
      check({op_tag(o), " result"}, int'(res), s & 255);
      check({op_tag(o), " carry"}, int'(cout), ec);
      check((o == 3'd2) ? "R7 ovf held" : "R6 ovf", int'(vf), ev);
      check("R4 zero", int'(zf), ((s & 255) == 0) ? 1 : 0);
      check("R5 neg", int'(nf), (s >> 7) & 1);
      check({op_tag(o), " wr_en"}, int'(we), (o == 3'd2) ? 0 : 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // Initial state: all-zero inputs give an add of zero (R1, R4).
      apply(3'd0, 8'h00, 8'h00, 1'b0, 1'b0);
      check("R4 zero at start", int'(zf), 1);
      check("R1 result at start", int'(res), 0);

      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] e;
         e = VEC[i];
         apply(e[31:29], e[28:21], e[20:13], e[12], e[11]);
         check({op_tag(e[31:29]), " result"}, int'(res), int'(e[10:3]));
         check({op_tag(e[31:29]), " carry"}, int'(cout), int'(e[2]));
         check((e[31:29] <= 3'd1) ? "R6 ovf" : "R7 ovf held", int'(vf), int'(e[1]));
         check({op_tag(e[31:29]), " wr_en"}, int'(we), int'(e[0]));
         check("R4 zero", int'(zf), (e[10:3] == 8'h00) ? 1 : 0);
         check("R5 neg", int'(nf), int'(e[10]));
      end

      // Compare ignores carry_i: same result with carry clear or set (R3).
      apply(3'd2, 8'h40, 8'h41, 1'b0, 1'b0);
      check("R3 cmp cin0", int'({cout, res}), 9'h0FF);
      apply(3'd2, 8'h40, 8'h41, 1'b1, 1'b0);
      check("R3 cmp cin1", int'({cout, res}), 9'h0FF);

      // Boundary sweeps over operands for add, subtract, compare (R1 R2 R3 R6).
      for (int a = 0; a < 256; a += 7) begin
         for (int b = 0; b < 256; b += 11) begin
            for (int c = 0; c < 2; c++) begin
               sweep_check(3'd0, 8'(a), 8'(b), 1'(c));
               sweep_check(3'd1, 8'(a), 8'(b), 1'(c));
               sweep_check(3'd2, 8'(a), 8'(b), 1'(c));
            end
         end
      end
      sweep_check(3'd1, 8'h00, 8'hFF, 1'b1);
      sweep_check(3'd0, 8'hFF, 8'hFF, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule